// File: doc/BRIEF.md
# Debug Power Request and Lock Controller

This block sits on the debug side of one processor core and lets debug software keep that core's power domain alive while it inspects it. Software writes a control register to ask the external power controller to power the core up and to keep it from powering down. The block drives those two requests out as level signals. It brings the controller's acknowledge and the external double-lock indication back in through two-flop synchronizers and shows both in a status register. Software can poll that register at any time.

Access to a small bank of protected debug words is granted only while the domain reports powered and the double lock is clear. Outside that window, protected reads return zero and protected writes are dropped. An OS lock bit comes out of reset set. Writing zero to the lock register releases it, and writing any non-zero value sets it again. The control register keeps its contents whatever the power status does, so software can save it, change it and later restore it.

Top module: `dbgpwr_ctl`

## Requirements
- R1: While `rst_ni` is low, the power-up and hold requests are 0, the OS lock is 1, `rvalid_o` and `rdata_o` are 0, both synchronizer chains are cleared, and access is not granted.
- R2: The control register is at byte address 0x40. Bit 0 is the power-up request and drives `pwr_up_req_o`. Bit 1 is the hold-on (no power-down) request and drives `no_pdn_req_o`. Both take effect on the edge after the write. A read returns the two bits with all other bits zero.
- R3: The control register changes only when software writes it. A change of the acknowledge or double-lock input leaves both request outputs and the read-back value unchanged, so a value that was read out and later written back restores the requests exactly.
- R4: The OS lock register is at byte address 0x48. Writing zero clears the lock and writing any non-zero value sets it. `os_lock_o` and read bit 0 show the lock state.
- R5: The status register is at byte address 0x44 and can be read at any time. Bit 0 is the powered-up flag, bit 1 is the double-lock flag, bit 2 is the OS lock and bit 3 is the access grant. Bits 0 and 1 follow `pwr_ack_i` and `dbl_lock_i` through two flip-flops, so an input change sampled on one edge shows two edges later.
- R6: `access_ok_o` is 1 exactly when the synchronized powered-up flag is 1 and the synchronized double-lock flag is 0.
- R7: The protected words sit at byte addresses 0x00, 0x04, 0x08 and 0x0C. A read of one of them while access is not granted returns zero.
- R8: A write to a protected word while access is not granted leaves the word unchanged. A later read made while access is granted returns the last value written while access was granted.
- R9: Reads have one cycle of latency. `rvalid_o` and `rdata_o` are updated on the edge after `rd_en_i`, and `rdata_o` is 0 in cycles without a read. A read and a write to the same address in the same cycle return the old value. An address with bits [1:0] not zero, or one outside the map, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the read strobe |
| rvalid_o | output | 1 | Read data valid |
| pwr_ack_i | input | 1 | Power controller acknowledge (domain powered), asynchronous |
| dbl_lock_i | input | 1 | Double-lock indication, asynchronous |
| pwr_up_req_o | output | 1 | Request to power the core domain up |
| no_pdn_req_o | output | 1 | Request to keep the core domain from powering down |
| os_lock_o | output | 1 | OS lock state |
| access_ok_o | output | 1 | Access to protected words granted |

## Verification
The hardest case to reach is the power domain dropping after access was granted, while software still holds its requests and protected data. Protected writes and reads must stop exactly two edges after the acknowledge falls, and the control value must survive untouched. The bench requests power, raises the acknowledge late so that software has to poll, fills the protected words, and then pulls the acknowledge and, separately, raises the double lock. During each outage it reads and writes the protected words. A random phase then toggles both inputs against random register traffic, and a behavioural model with its own two-deep delay line checks every cycle.

// File: rtl/dbgpwr_pkg.sv
package dbgpwr_pkg;

    // word indices (byte address >> 2) of the fixed registers
    localparam int unsigned CTRL_WORD = 16;
    localparam int unsigned STAT_WORD = 17;
    localparam int unsigned OSL_WORD  = 18;

    // control register fields
    localparam int unsigned CTRL_PUP_BIT  = 0;
    localparam int unsigned CTRL_HOLD_BIT = 1;

    // status register fields
    localparam int unsigned STAT_PWR_BIT  = 0;
    localparam int unsigned STAT_DLK_BIT  = 1;
    localparam int unsigned STAT_OSL_BIT  = 2;
    localparam int unsigned STAT_PERM_BIT = 3;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_BANK,
        TGT_CTRL,
        TGT_STAT,
        TGT_OSL
    } tgt_e;

    function automatic tgt_e decode_word(input int unsigned word,
                                         input logic        aligned,
                                         input int unsigned nprot);
        tgt_e t;
        t = TGT_NONE;
        if (aligned) begin
            if (word < nprot)           t = TGT_BANK;
            else if (word == CTRL_WORD) t = TGT_CTRL;
            else if (word == STAT_WORD) t = TGT_STAT;
            else if (word == OSL_WORD)  t = TGT_OSL;
        end
        return t;
    endfunction

endpackage

// File: rtl/dbgpwr_sync.sv
module dbgpwr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/dbgpwr_bank.sv
module dbgpwr_bank #(
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              grant_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_word_o
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && grant_i) begin
            bank_d.word[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign rd_word_o = bank_q.word[idx_i];

endmodule

// File: rtl/dbgpwr_regs.sv
module dbgpwr_regs
    import dbgpwr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  tgt_e              tgt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] bank_rd_i,
    input  logic              pwr_sync_i,
    input  logic              dlk_sync_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              pup_o,
    output logic              hold_o,
    output logic              os_lock_o,
    output logic              grant_o
);

    typedef struct packed {
        logic              pup;
        logic              hold;
        logic              oslock;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  grant;

    assign grant = pwr_sync_i & ~dlk_sync_i;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_en_i;
        st_d.rdata  = '0;

        if (rd_en_i) begin
            unique case (tgt_i)
                TGT_BANK: st_d.rdata = grant ? bank_rd_i : '0;
                TGT_CTRL: begin
                    st_d.rdata[CTRL_PUP_BIT]  = st_q.pup;
                    st_d.rdata[CTRL_HOLD_BIT] = st_q.hold;
                end
                TGT_STAT: begin
                    st_d.rdata[STAT_PWR_BIT]  = pwr_sync_i;
                    st_d.rdata[STAT_DLK_BIT]  = dlk_sync_i;
                    st_d.rdata[STAT_OSL_BIT]  = st_q.oslock;
                    st_d.rdata[STAT_PERM_BIT] = grant;
                end
                TGT_OSL:  st_d.rdata[0] = st_q.oslock;
                default:  st_d.rdata = '0;
            endcase
        end

        if (wr_en_i) begin
            unique case (tgt_i)
                TGT_CTRL: begin
                    st_d.pup  = wdata_i[CTRL_PUP_BIT];
                    st_d.hold = wdata_i[CTRL_HOLD_BIT];
                end
                TGT_OSL:  st_d.oslock = |wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.oslock <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = st_q.rdata;
    assign rvalid_o  = st_q.rvalid;
    assign pup_o     = st_q.pup;
    assign hold_o    = st_q.hold;
    assign os_lock_o = st_q.oslock;
    assign grant_o   = grant;

endmodule

// File: rtl/dbgpwr_ctl.sv
module dbgpwr_ctl
    import dbgpwr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PROT = 4,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    input  logic              pwr_ack_i,
    input  logic              dbl_lock_i,
    output logic              pwr_up_req_o,
    output logic              no_pdn_req_o,
    output logic              os_lock_o,
    output logic              access_ok_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned IDX_W  = (NUM_PROT > 1) ? $clog2(NUM_PROT) : 1;

    logic [WORD_W-1:0] word;
    logic              aligned;
    tgt_e              tgt;
    logic [1:0]        sync_q;
    logic [DATA_W-1:0] bank_rd;
    logic              grant;

    assign word    = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign tgt     = decode_word(32'(word), aligned, NUM_PROT);

    dbgpwr_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_LEN)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({dbl_lock_i, pwr_ack_i}),
        .sync_o  (sync_q)
    );

    dbgpwr_bank #(
        .NUM_WORDS (NUM_PROT),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) i_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i && (tgt == TGT_BANK)),
        .grant_i   (grant),
        .idx_i     (word[IDX_W-1:0]),
        .wdata_i   (wdata_i),
        .rd_word_o (bank_rd)
    );

    dbgpwr_regs #(
        .DATA_W (DATA_W)
    ) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .tgt_i      (tgt),
        .wdata_i    (wdata_i),
        .bank_rd_i  (bank_rd),
        .pwr_sync_i (sync_q[0]),
        .dlk_sync_i (sync_q[1]),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o),
        .pup_o      (pwr_up_req_o),
        .hold_o     (no_pdn_req_o),
        .os_lock_o  (os_lock_o),
        .grant_o    (grant)
    );

    assign access_ok_o = grant;

endmodule

// File: rtl/dbgpwr_ctl_chk.sv
module dbgpwr_ctl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_PROT = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              pwr_ack_i,
    input logic              dbl_lock_i,
    input logic              pwr_up_req_o,
    input logic              no_pdn_req_o,
    input logic              os_lock_o,
    input logic              access_ok_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CTRL_W = WORD_W'(dbgpwr_pkg::CTRL_WORD);
    localparam logic [WORD_W-1:0] OSL_W  = WORD_W'(dbgpwr_pkg::OSL_WORD);
    localparam logic [WORD_W-1:0] NPR_W  = WORD_W'(NUM_PROT);

    logic       al, is_ctrl, is_osl, is_bank;
    logic [1:0] settle_q;

    assign al      = (addr_i[1:0] == 2'b00);
    assign is_ctrl = al && (addr_i[ADDR_W-1:2] == CTRL_W);
    assign is_osl  = al && (addr_i[ADDR_W-1:2] == OSL_W);
    assign is_bank = al && (addr_i[ADDR_W-1:2] < NPR_W);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && is_ctrl) |=> (pwr_up_req_o == $past(wdata_i[0]))
                                 && (no_pdn_req_o == $past(wdata_i[1])));

    assert_ctrl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && is_ctrl) |=> $stable(pwr_up_req_o) && $stable(no_pdn_req_o));

    assert_oslock_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && is_osl) |=> (os_lock_o == $past(|wdata_i)));

    assert_grant_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settle_q >= 2'd2) |-> (access_ok_o == ($past(pwr_ack_i, 2) && !$past(dbl_lock_i, 2))));

    assert_prot_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && is_bank && !access_ok_o) |=> (rdata_o == '0));

    assert_rvalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rvalid_o);

    assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (!rvalid_o && (rdata_o == '0)));

endmodule

bind dbgpwr_ctl dbgpwr_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PROT (NUM_PROT)
) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .pwr_ack_i    (pwr_ack_i),
    .dbl_lock_i   (dbl_lock_i),
    .pwr_up_req_o (pwr_up_req_o),
    .no_pdn_req_o (no_pdn_req_o),
    .os_lock_o    (os_lock_o),
    .access_ok_o  (access_ok_o)
);

// File: tb/test_dbgpwr_ctl.sv
`timescale 1ns/1ps
module test_dbgpwr_ctl;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_STAT = 8'h44;
    localparam logic [7:0] A_OSL  = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, pup, hold, osl, aok;
    logic        ack = 1'b0, dlk = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dbgpwr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(4), .SYNC_LEN(2)) i_dbgpwr_ctl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .pwr_ack_i(ack), .dbl_lock_i(dlk), .pwr_up_req_o(pup),
        .no_pdn_req_o(hold), .os_lock_o(osl), .access_ok_o(aok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        m_pup = 0, m_hold = 0, m_osl = 1;
    logic        m_p1 = 0, m_p2 = 0, m_d1 = 0, m_d2 = 0;
    logic [31:0] m_bank [4];
    logic        m_rv = 0;
    logic [31:0] m_rd = 0;
    string       m_tag = "R9";
    bit          live = 0;

    function automatic int kind(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a < 8'h10)  return 1;
        if (a == A_CTRL) return 2;
        if (a == A_STAT) return 3;
        if (a == A_OSL)  return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pup = 0; m_hold = 0; m_osl = 1;
            m_p1 = 0; m_p2 = 0; m_d1 = 0; m_d2 = 0;
            for (int i = 0; i < 4; i++) m_bank[i] = '0;
            m_rv = 0; m_rd = '0; m_tag = "R1";
            live = 1;
        end else begin
            logic perm;
            int   k;
            perm  = m_p2 && !m_d2;
            k     = kind(addr);
            m_rv  = rd_en;
            m_rd  = '0;
            m_tag = "R9";
            if (rd_en) begin
                case (k)
                    1: begin m_rd = perm ? m_bank[addr[3:2]] : '0; m_tag = perm ? "R8" : "R7"; end
                    2: begin m_rd = {30'd0, m_hold, m_pup}; m_tag = "R2"; end
                    3: begin m_rd = {28'd0, perm, m_osl, m_d2, m_p2}; m_tag = "R5"; end
                    4: begin m_rd = {31'd0, m_osl}; m_tag = "R4"; end
                    default: m_tag = "R9";
                endcase
            end
            if (wr_en) begin
                case (k)
                    1: if (perm) m_bank[addr[3:2]] = wdata;
                    2: begin m_pup = wdata[0]; m_hold = wdata[1]; end
                    4: m_osl = |wdata;
                    default: ;
                endcase
            end
            m_p2 = m_p1; m_p1 = ack;
            m_d2 = m_d1; m_d1 = dlk;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            check(rst_n ? "R2" : "R1", {31'd0, pup},  {31'd0, m_pup});
            check(rst_n ? "R2" : "R1", {31'd0, hold}, {31'd0, m_hold});
            check(rst_n ? "R4" : "R1", {31'd0, osl},  {31'd0, m_osl});
            check(rst_n ? "R6" : "R1", {31'd0, aok},  {31'd0, (m_p2 && !m_d2)});
            check(rst_n ? "R9" : "R1", {31'd0, rvalid}, {31'd0, m_rv});
            check(rst_n ? m_tag : "R1", rdata, m_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask

    task automatic rd_now(input logic [7:0] a, output logic [31:0] v);
        cyc(0, 1, a, '0);
        cyc(0, 0, '0, '0);
        v = rdata;
    endtask

    logic [31:0] v, saved;

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {31'd0, osl}, 32'd1);
        check("R1", {30'd0, hold, pup}, 32'd0);
        rst_n = 1'b1;

        // protected access with no power: reads zero, writes dropped
        cyc(1, 0, 8'h04, 32'hDEAD_BEEF);
        rd_now(8'h04, v); check("R7", v, 32'd0);

        // request power, acknowledge late, poll status
        cyc(1, 0, A_CTRL, 32'h1);
        repeat (5) cyc(0, 0, '0, '0);
        ack = 1'b1;
        for (int i = 0; i < 20; i++) begin
            rd_now(A_STAT, v);
            if (v[0]) break;
        end
        check("R5", v & 32'h9, 32'h9);
        cyc(1, 0, A_CTRL, 32'hFFFF_FFFF);
        rd_now(A_CTRL, v); check("R2", v, 32'h3);

        // fill protected words, then read back
        for (int i = 0; i < 4; i++) cyc(1, 0, 8'(i * 4), 32'h1000 + i);
        rd_now(8'h04, v); check("R8", v, 32'h1001);

        // double lock: access removed two edges later
        dlk = 1'b1;
        repeat (3) cyc(0, 0, '0, '0);
        check("R6", {31'd0, aok}, 32'd0);
        cyc(1, 0, 8'h08, 32'h5555_0000);
        rd_now(8'h08, v); check("R7", v, 32'd0);
        dlk = 1'b0;
        repeat (3) cyc(0, 0, '0, '0);
        rd_now(8'h08, v); check("R8", v, 32'h1002);

        // domain drops: requests held
        ack = 1'b0;
        repeat (4) cyc(0, 0, '0, '0);
        check("R3", {30'd0, hold, pup}, 32'h3);
        rd_now(A_CTRL, saved); check("R3", saved, 32'h3);
        cyc(1, 0, A_CTRL, 32'h0);
        cyc(1, 0, A_CTRL, saved);
        cyc(0, 0, '0, '0);
        check("R3", {30'd0, hold, pup}, 32'h3);
        ack = 1'b1;
        repeat (3) cyc(0, 0, '0, '0);

        // OS lock
        cyc(1, 0, A_OSL, 32'h0);
        rd_now(A_OSL, v); check("R4", v, 32'h0);
        cyc(1, 0, A_OSL, 32'h40);
        rd_now(A_STAT, v); check("R4", {31'd0, v[2]}, 32'd1);
        cyc(1, 0, A_OSL, 32'h0);

        // same-cycle read and write, misaligned and unmapped
        cyc(1, 1, 8'h00, 32'hABCD);
        cyc(0, 0, '0, '0); check("R9", rdata, 32'h1000);
        rd_now(8'h00, v); check("R8", v, 32'hABCD);
        rd_now(8'h41, v); check("R9", v, 32'd0);
        cyc(1, 0, 8'h42, 32'h0);
        cyc(0, 0, '0, '0); check("R9", {30'd0, hold, pup}, 32'h3);
        rd_now(8'h80, v); check("R9", v, 32'd0);

        // random traffic with input toggling
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 6))
                0: a = A_CTRL;
                1: a = A_STAT;
                2: a = A_OSL;
                3: a = 8'($urandom_range(0, 255));
                default: a = 8'($urandom_range(0, 3) * 4);
            endcase
            if ($urandom_range(0, 9) == 0) ack = ~ack;
            if ($urandom_range(0, 14) == 0) dlk = ~dlk;
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom);
        end
        cyc(0, 0, '0, '0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule